// File: doc/BRIEF.md
# In-band loop code detector

This block watches a serial receive bit stream for two repeating in-band loop codes, one that requests a line loopback (the actuate code) and one that releases it (the deactuate code). Each code has its own detector. A detector first searches for the code's phase. Once it finds the phase, it compares every following bit against the expected pattern and counts the mismatches over a fixed window of counted bits.

A status flag goes high at the end of the first window that passes the error limit. It stays high while later windows keep passing. It drops at the end of the first failing window, and the detector then searches for phase again.

The stream arrives one bit per strobe. When the receive framer reports alignment, the bit marked as the frame start is the framing bit. That bit is left out of both the comparison and the pattern phase. Without alignment, every strobed bit takes part. The window length is a parameter: its default of 51,200 bits gives a window of just over 33.16 ms at 1.544 Mb/s, and simulation uses a shorter window.

Top module: `inband_loop_detector`

## Requirements
- R1: There are two independent detectors. The actuate detector drives `act_det` and looks for the repeating pattern 00001. The deactuate detector drives `deact_det` and looks for the repeating pattern 001. Patterns are written with the earliest received bit leftmost.
- R2: A searching detector locks when its last L counted bits equal its pattern in order, where L is the pattern length. The window starts with the next counted bit, which is expected to equal the first pattern bit.
- R3: A window is WIN counted bits long. The window passes when it holds fewer than WIN/100 (integer division) mismatches, and fails when it holds WIN/100 or more.
- R4: A flag rises only on the clock edge that consumes the last bit of a passing window. The registered output shows the new value after that edge.
- R5: A set flag stays high while windows keep passing. It clears on the edge that ends a failing window, and the detector returns to searching.
- R6: While `frm_aligned` is 1, a strobed bit with `frm_start` = 1 is ignored. It is not compared, not counted, not entered into the history, and it does not advance the pattern phase.
- R7: While `frm_aligned` is 0, `frm_start` has no effect, and every strobed bit is counted.
- R8: Cycles with `bit_vld` = 0 have no effect on either detector.
- R9: Driving `rst_n` low clears both flags, all counters and the phase lock at once. After `rst_n` rises, the detectors resume on the third rising clock edge, counting the first edge that sees `rst_n` high as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received data bit |
| frm_aligned | input | 1 | Frame alignment is established |
| frm_start | input | 1 | The current bit is the first bit of a frame |
| act_det | output | 1 | Actuate code qualified |
| deact_det | output | 1 | Deactuate code qualified |

## Verification
The bench builds the block with WIN = 400, which makes the error limit 4 mismatches per window. A code stream then qualifies within a few hundred strobes, so one run can cover lock, set, hold, clear and relock several times. With errors injected every 150 bits, no window can hold more than three errors, so the flag must hold. With errors every 100 bits, every window holds four, so the flag must clear. These two cases sit on either side of the threshold. The framing cases insert an extra bit every 50 strobes: when it is marked as a framing bit under alignment it must be ignored, and without alignment it must slip the phase and make the windows fail.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int unsigned N_CODES   = 2;
  localparam int unsigned ACT_LEN   = 5;
  localparam logic [7:0]  ACT_PAT   = 8'b0000_0001; // 00001, earliest bit at MSB
  localparam int unsigned DEACT_LEN = 3;
  localparam logic [7:0]  DEACT_PAT = 8'b0000_0001; // 001
  typedef enum logic {ST_SRCH = 1'b0, ST_LOCK = 1'b1} det_st_e;
endpackage

// File: rtl/lcd_detector.sv
module lcd_detector
  import lcd_pkg::*;
#(
  parameter int unsigned LEN   = 5,
  parameter logic [7:0]  PAT_W = 8'h01,
  parameter int unsigned WIN   = 51200
) (
  input  logic clk,
  input  logic rst_i,
  input  logic take,
  input  logic bit_in,
  output logic flag,
  output logic win_end,
  output logic win_pass
);
  localparam int unsigned CW      = $clog2(WIN + 1);
  localparam int unsigned PW      = $clog2(LEN);
  localparam int unsigned ERR_LIM = WIN / 100;
  localparam logic [LEN-1:0] PAT  = PAT_W[LEN-1:0];

  det_st_e        st_q, st_d;
  logic [LEN-1:0] hist_q, hist_d;
  logic [LEN-1:0] fill_q, fill_d;
  logic [PW-1:0]  ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  err_q, err_d;
  logic           flag_q, flag_d;
  logic           exp_bit, mis, last;
  logic [CW-1:0]  err_tot;

  always_comb begin
    exp_bit  = PAT[PW'(LEN - 1) - ph_q];
    mis      = bit_in ^ exp_bit;
    err_tot  = err_q + CW'(mis);
    last     = (cnt_q == CW'(WIN - 1));
    win_end  = take && (st_q == ST_LOCK) && last;
    win_pass = (err_tot < CW'(ERR_LIM));

    st_d   = st_q;
    hist_d = {hist_q[LEN-2:0], bit_in};
    fill_d = {fill_q[LEN-2:0], 1'b1};
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    flag_d = flag_q;
    case (st_q)
      ST_SRCH: begin
        if ((&fill_d) && (hist_d == PAT)) begin
          st_d  = ST_LOCK;
          ph_d  = '0;
          cnt_d = '0;
          err_d = '0;
        end
      end
      default: begin
        ph_d  = (ph_q == PW'(LEN - 1)) ? '0 : ph_q + PW'(1);
        cnt_d = cnt_q + CW'(1);
        err_d = err_tot;
        if (last) begin
          flag_d = win_pass;
          cnt_d  = '0;
          err_d  = '0;
          if (!win_pass) st_d = ST_SRCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_SRCH;
      hist_q <= '0;
      fill_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      err_q  <= '0;
      flag_q <= 1'b0;
    end else if (take) begin
      st_q   <= st_d;
      hist_q <= hist_d;
      fill_q <= fill_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/inband_loop_detector.sv
module inband_loop_detector
  import lcd_pkg::*;
#(
  parameter int unsigned WIN = 51200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic frm_aligned,
  input  logic frm_start,
  output logic act_det,
  output logic deact_det
);
  logic [1:0]         rsync_q;
  logic               rst_i;
  logic               take;
  logic [N_CODES-1:0] det, win_end, win_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // framing bit is skipped only under alignment
  assign take = bit_vld && !(frm_aligned && frm_start);

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    lcd_detector #(
      .LEN   ((g == 0) ? ACT_LEN : DEACT_LEN),
      .PAT_W ((g == 0) ? ACT_PAT : DEACT_PAT),
      .WIN   (WIN)
    ) det_i (
      .clk      (clk),
      .rst_i    (rst_i),
      .take     (take),
      .bit_in   (bit_in),
      .flag     (det[g]),
      .win_end  (win_end[g]),
      .win_pass (win_pass[g])
    );
  end

  assign act_det   = det[0];
  assign deact_det = det[1];
endmodule

// File: rtl/inband_loop_detector_chk.sv
module inband_loop_detector_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       bit_vld,
  input logic       act_det,
  input logic       deact_det,
  input logic [1:0] win_end,
  input logic [1:0] win_pass
);
  a_r4_act_rise_on_pass: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(act_det) |-> $past(win_end[0] && win_pass[0]));
  a_r4_deact_rise_on_pass: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(deact_det) |-> $past(win_end[1] && win_pass[1]));
  a_r5_act_fall_on_fail: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(act_det) |-> $past(win_end[0] && !win_pass[0]));
  a_r5_deact_fall_on_fail: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(deact_det) |-> $past(win_end[1] && !win_pass[1]));
  a_r8_idle_no_change: assert property (@(posedge clk) disable iff (!rst_i)
    !bit_vld |=> ($stable(act_det) && $stable(deact_det)));
endmodule

bind inband_loop_detector inband_loop_detector_chk chk_i (
  .clk       (clk),
  .rst_i     (rst_i),
  .bit_vld   (bit_vld),
  .act_det   (act_det),
  .deact_det (deact_det),
  .win_end   (win_end),
  .win_pass  (win_pass)
);

// File: tb/inband_loop_detector_tb.sv
module inband_loop_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, bin = 1'b0, al = 1'b0, fs = 1'b0;
  logic act_det, deact_det;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inband_loop_detector #(.WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(vld), .bit_in(bin),
    .frm_aligned(al), .frm_start(fs), .act_det(act_det), .deact_det(deact_det));

  // ---------------- behavioural reference model ----------------
  int plen [2] = '{5, 3};
  function automatic bit pbit(int k, int ph);
    return (ph == plen[k] - 1);   // both codes: zeros then a single one
  endfunction

  bit m_hist [2][$];
  int m_lock [2], m_ph [2], m_cnt [2], m_err [2];
  bit m_flag [2];
  int rel = 0;

  function automatic void m_clear();
    for (int k = 0; k < 2; k++) begin
      m_hist[k].delete();
      m_lock[k] = 0; m_ph[k] = 0; m_cnt[k] = 0; m_err[k] = 0; m_flag[k] = 0;
    end
  endfunction

  function automatic void m_bit(int k, bit b);
    bit match;
    m_hist[k].push_back(b);
    if (m_hist[k].size() > plen[k]) void'(m_hist[k].pop_front());
    if (m_lock[k] == 0) begin
      match = (m_hist[k].size() == plen[k]);
      for (int i = 0; i < m_hist[k].size(); i++)
        if (m_hist[k][i] != pbit(k, i)) match = 0;
      if (match) begin
        m_lock[k] = 1; m_ph[k] = 0; m_cnt[k] = 0; m_err[k] = 0;
      end
    end else begin
      if (b != pbit(k, m_ph[k])) m_err[k]++;
      m_ph[k] = (m_ph[k] + 1) % plen[k];
      m_cnt[k]++;
      if (m_cnt[k] == WIN) begin
        m_flag[k] = (m_err[k] < WIN / 100);
        if (!m_flag[k]) m_lock[k] = 0;
        m_cnt[k] = 0; m_err[k] = 0;
      end
    end
  endfunction

  initial m_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_clear();
    end else if (rel < 2) begin
      rel++; m_clear();
    end else if (vld && !(al && fs)) begin
      for (int k = 0; k < 2; k++) m_bit(k, bin);
    end
  end

  // ---------------- checking ----------------
  task automatic check(input logic got, input logic exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  task automatic cmp_model();
    check(act_det, m_flag[0], "R4/R5 act_det vs model");
    check(deact_det, m_flag[1], "R4/R5 deact_det vs model");
  endtask

  task automatic step(input logic v, input logic b, input logic a, input logic f);
    @(negedge clk);
    cmp_model();
    vld = v; bin = b; al = a; fs = f;
  endtask

  int tx_ph = 0;
  // send n code bits; err_every: invert one bit per period; gap_every: idle strobe
  // with junk; ins_every: extra bit (value 1) flagged with ins_fs before a code bit;
  // fs_real: raise frm_start on code bits
  task automatic send(input int k, input int n, input int err_every, input int gap_every,
                      input int ins_every, input logic a, input logic ins_fs,
                      input logic fs_real);
    for (int i = 0; i < n; i++) begin
      bit b;
      if (gap_every > 0 && i % gap_every == 0) step(1'b0, 1'b1, a, 1'b0);
      if (ins_every > 0 && i % ins_every == ins_every - 1) step(1'b1, 1'b1, a, ins_fs);
      b = pbit(k, tx_ph % plen[k]);
      if (err_every > 0 && i % err_every == err_every - 1) b = ~b;
      step(1'b1, b, a, fs_real && (i % 7 == 0));
      tx_ph++;
    end
    step(1'b0, 1'b0, a, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vld = 0; bin = 0; al = 0; fs = 0;
    repeat (3) @(negedge clk);
    check(act_det, 1'b0, "R9 act_det in reset");
    check(deact_det, 1'b0, "R9 deact_det in reset");
    rst_n = 1'b1; tx_ph = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2 R4: clean actuate code qualifies only the actuate flag
    send(0, 420, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b1, "R1 R4 act_det after clean window");
    check(deact_det, 1'b0, "R1 deact_det stays low on actuate code");
    // R3: three errors per window at most -> must hold
    send(0, 1200, 150, 0, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b1, "R3 act_det holds with 3 errors per window");
    // R3 R5: four errors per window -> must clear
    send(0, 900, 100, 0, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b0, "R3 R5 act_det cleared by failing window");
    // R2 R5: relock after clear
    send(0, 900, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b1, "R2 R5 act_det relocks");
    // R1 R5: switch to deactuate code
    tx_ph = 0;
    send(1, 1300, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b0, "R1 R5 act_det drops on deactuate code");
    check(deact_det, 1'b1, "R1 deact_det set on deactuate code");
    // R9: reset mid-run
    do_reset();
    // R8: idle strobes with junk between bits
    send(0, 900, 0, 3, 0, 1'b0, 1'b0, 1'b0);
    check(act_det, 1'b1, "R8 act_det with idle strobes");
    // R6: aligned, inserted framing bits flagged by frm_start are skipped
    do_reset();
    send(0, 1300, 0, 0, 50, 1'b1, 1'b1, 1'b0);
    check(act_det, 1'b1, "R6 act_det with skipped framing bits");
    // R7: unaligned, frm_start on code bits has no effect
    do_reset();
    send(0, 900, 0, 0, 0, 1'b0, 1'b0, 1'b1);
    check(act_det, 1'b1, "R7 act_det with frm_start ignored");
    // R7: unaligned, extra flagged bits are counted and slip the phase
    send(0, 1300, 0, 0, 50, 1'b0, 1'b1, 1'b0);
    check(act_det, 1'b0, "R7 act_det fails when extra bits are counted");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule